// File: doc/BRIEF.md
# Fiber Link Supervisor

This controller decides whether a fiber Ethernet receive link is usable. An analog level detector provides a debounced flag that tells whether received light is above threshold. The controller qualifies that flag over time, so it moves between a low-light state and a link-pass state. In low-light, the transmit data path, the receiver output and the loopback path are disabled. The transmitter is told to send a 1 MHz idle pattern instead, and the active-low link LED is dark.

When light returns, the flag must hold for a qualification interval of `QUAL_CYCLES` clock cycles. The controller then waits for a window whose length is drawn from a free-running LFSR and clamped between `WAIT_MIN` and `WAIT_MAX` cycles. After that wait it re-enables the paths, but only once the transmit input is idle and no receive data is active. Losing light takes twice the qualification interval to drop the link. A clock divider produces the 1 MHz idle tone. All durations are parameters, so that benches can use short values.

Top module: `fiber_link_supervisor`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) puts the block in low-light. After that edge `tx_en`, `rx_en` and `lb_en` are 0, `idle_sel` is 1, `led_n` is 1 and `idle_tone` is 0.
- R2: The outputs depend only on the state. Outside link-pass, `tx_en`=`rx_en`=`lb_en`=0 and `idle_sel`=`led_n`=1. In link-pass, `tx_en`=`rx_en`=`lb_en`=1 and `idle_sel`=`led_n`=0.
- R3: Leaving low-light needs `sig_ok` high at `QUAL_CYCLES` consecutive rising edges. A single edge with `sig_ok` low restarts the count from zero.
- R4: Suppose `sig_ok` rises and stays high with `tx_idle`=1 and `rx_active`=0. Then the enables go high after N rising edges, counted from the first edge that samples `sig_ok` high, where QUAL_CYCLES+WAIT_MIN+1 <= N <= QUAL_CYCLES+WAIT_MAX+1.
- R5: Once the wait has ended, link-pass is entered only at an edge where `tx_idle`=1 and `rx_active`=0. Until then all enables stay 0. They go high one edge after both lines become quiet.
- R6: If `sig_ok` is low at any edge during the wait or the quiet hold, the block returns to low-light without enabling anything. A later rise again needs a full qualification and a new wait, as in R4.
- R7: In link-pass, `sig_ok` low at 2*QUAL_CYCLES consecutive edges drops to low-light at the last of those edges. A high edge before then keeps link-pass and restarts the drop count.
- R8: `idle_tone` runs freely from reset and toggles every `TONE_HALF` edges. After reset is released, its value following edge n is (n / TONE_HALF) mod 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_ok | input | 1 | Debounced received-light-above-threshold flag |
| tx_idle | input | 1 | Transmit input is idle |
| rx_active | input | 1 | Receive data is active |
| tx_en | output | 1 | Transmit data path enable |
| rx_en | output | 1 | Receiver output enable |
| lb_en | output | 1 | Loopback path enable |
| idle_sel | output | 1 | Selects the 1 MHz idle pattern on the transmitter |
| idle_tone | output | 1 | Divided idle tone, period 2*TONE_HALF cycles |
| led_n | output | 1 | Link LED drive, low lights the LED |

## Verification
The assertions assume that `sig_ok`, `tx_idle` and `rx_active` are synchronous to `clk`, and that they hold one value through each cycle. The assertions on the enable edges relate each rise or fall of `tx_en` to the input values sampled at the edge before. The bench changes every input one time unit after a rising edge, so each edge sees settled levels. The random stimulus draws the lengths of high runs on `sig_ok` that are shorter than the qualification interval. Qualification then fails, and only a sustained run that follows can raise the link.

// File: rtl/fiber_link_supervisor.sv
module fiber_link_supervisor #(
  parameter int unsigned QUAL_CYCLES = 875_000,
  parameter int unsigned WAIT_MIN    = 6_250_000,
  parameter int unsigned WAIT_MAX    = 18_750_000,
  parameter int unsigned TONE_HALF   = 12,
  parameter logic [31:0] LFSR_SEED   = 32'hACE1_2468
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_ok,
  input  logic tx_idle,
  input  logic rx_active,
  output logic tx_en,
  output logic rx_en,
  output logic lb_en,
  output logic idle_sel,
  output logic idle_tone,
  output logic led_n
);

  localparam int unsigned SPAN = WAIT_MAX - WAIT_MIN;
  localparam int QW = $clog2(2 * QUAL_CYCLES + 1);
  localparam int WW = $clog2(WAIT_MAX + 1);
  localparam int SW = (SPAN > 1) ? $clog2(SPAN + 1) : 1;
  localparam int TW = $clog2(TONE_HALF + 1);
  localparam int unsigned RUN_MAX = QUAL_CYCLES + WAIT_MIN + 1;
  localparam int RW = $clog2(RUN_MAX + 1);

  typedef enum logic [1:0] {S_LOW, S_WAIT, S_HOLD, S_PASS} state_t;

  state_t        st;
  logic [QW-1:0] qcnt;
  logic [WW-1:0] wcnt, wload;
  logic [31:0]   lfsr;
  logic [TW-1:0] tcnt;
  logic [SW-1:0] rnd;
  logic          quiet;

  assign quiet = tx_idle && !rx_active;
  assign rnd   = lfsr[SW-1:0];
  assign wload = (32'(rnd) > SPAN) ? WW'(WAIT_MAX - 1) : WW'(WAIT_MIN - 1 + 32'(rnd));

  assign tx_en    = (st == S_PASS);
  assign rx_en    = (st == S_PASS);
  assign lb_en    = (st == S_PASS);
  assign idle_sel = (st != S_PASS);
  assign led_n    = (st != S_PASS);

  always_ff @(posedge clk) begin
    if (rst) lfsr <= LFSR_SEED;
    else     lfsr <= {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt      <= '0;
      idle_tone <= 1'b0;
    end else if (tcnt == TW'(TONE_HALF - 1)) begin
      tcnt      <= '0;
      idle_tone <= ~idle_tone;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_LOW;
      qcnt <= '0;
      wcnt <= '0;
    end else begin
      case (st)
        S_LOW:
          if (!sig_ok) qcnt <= '0;
          else if (qcnt == QW'(QUAL_CYCLES - 1)) begin
            st   <= S_WAIT;
            qcnt <= '0;
            wcnt <= wload;
          end else qcnt <= qcnt + 1'b1;
        S_WAIT:
          if (!sig_ok) st <= S_LOW;
          else if (wcnt == '0) st <= S_HOLD;
          else wcnt <= wcnt - 1'b1;
        S_HOLD:
          if (!sig_ok) st <= S_LOW;
          else if (quiet) st <= S_PASS;
        S_PASS:
          if (sig_ok) qcnt <= '0;
          else if (qcnt == QW'(2 * QUAL_CYCLES - 1)) begin
            st   <= S_LOW;
            qcnt <= '0;
          end else qcnt <= qcnt + 1'b1;
        default: st <= S_LOW;
      endcase
    end
  end

  logic [RW-1:0] run;
  always_ff @(posedge clk) begin
    if (rst || !sig_ok) run <= '0;
    else if (run != RW'(RUN_MAX)) run <= run + 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!tx_en && !rx_en && !lb_en && idle_sel && led_n && !idle_tone));

  a_r4_min_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> (run >= RW'(RUN_MAX)));

  a_r5_quiet_on_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> ($past(tx_idle) && !$past(rx_active) && $past(sig_ok)));

  a_r7_drop_needs_dark: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |-> !$past(sig_ok));

  a_r8_tone_steady: assert property (@(posedge clk) disable iff (rst)
    (tcnt != TW'(TONE_HALF - 1)) |=> $stable(idle_tone));

endmodule

// File: tb/fiber_link_supervisor_bench.sv
module fiber_link_supervisor_bench;
  localparam int Q = 8, WMIN = 20, WMAX = 50, TH = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic sig_ok = 1'b0, tx_idle = 1'b1, rx_active = 1'b0;
  logic tx_en, rx_en, lb_en, idle_sel, idle_tone, led_n;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  fiber_link_supervisor #(.QUAL_CYCLES(Q), .WAIT_MIN(WMIN), .WAIT_MAX(WMAX), .TONE_HALF(TH))
    u_fiber_link_supervisor (.clk(clk), .rst(rst), .sig_ok(sig_ok), .tx_idle(tx_idle),
      .rx_active(rx_active), .tx_en(tx_en), .rx_en(rx_en), .lb_en(lb_en),
      .idle_sel(idle_sel), .idle_tone(idle_tone), .led_n(led_n));

  function automatic bit in_window(int n);
    return n >= Q + WMIN + 1 && n <= Q + WMAX + 1;
  endfunction

  function automatic int tone_at(int n);
    return (n / TH) % 2;
  endfunction

  function automatic bit low_ok();
    return !tx_en && !rx_en && !lb_en && idle_sel && led_n;
  endfunction

  function automatic bit pass_ok();
    return tx_en && rx_en && lb_en && !idle_sel && !led_n;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic measure_rise(string req);
    int n = 0, bad = 0;
    sig_ok = 1'b1;
    do begin
      step(); n++;
      if (!tx_en && !low_ok()) bad++;
    end while (!tx_en && n < Q + WMAX + 20);
    chk(in_window(n), req, "edges to enable", n, Q + WMIN + 1);
    chk(bad == 0, "R2", "low-light output mismatches", bad, 0);
    chk(pass_ok(), "R2", "pass outputs", {tx_en, rx_en, lb_en, idle_sel, led_n}, 5'b11100);
  endtask

  task automatic drop_exact(string req);
    int n = 0;
    sig_ok = 1'b0;
    do begin step(); n++; end while (tx_en && n < 4 * Q);
    chk(n == 2 * Q, req, "edges to drop", n, 2 * Q);
    chk(low_ok(), "R2", "low-light outputs", {tx_en, rx_en, lb_en, idle_sel, led_n}, 5'b00011);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int bad;
    void'($urandom(32'd4663));
    repeat (3) step();
    chk(low_ok() && !idle_tone, "R1", "reset outputs",
        {tx_en, rx_en, lb_en, idle_sel, led_n, idle_tone}, 6'b000110);
    rst = 1'b0;
    bad = 0;
    for (int n = 1; n <= 4 * TH; n++) begin
      step();
      if (int'(idle_tone) != tone_at(n)) bad++;
    end
    chk(bad == 0, "R8", "tone mismatches", bad, 0);

    // R3: a run one edge short, then one low edge, restarts qualification
    sig_ok = 1'b1;
    repeat (Q - 1) step();
    sig_ok = 1'b0; step();
    chk(!tx_en, "R3", "enable after short run", tx_en, 0);
    measure_rise("R3");

    // R7: a gap one edge short of 2Q keeps the link
    sig_ok = 1'b0;
    repeat (2 * Q - 1) step();
    chk(tx_en, "R7", "still pass after short gap", tx_en, 1);
    sig_ok = 1'b1; step();
    drop_exact("R7");

    // R5: busy transmit holds off the enable
    tx_idle = 1'b0; sig_ok = 1'b1;
    repeat (Q + WMAX + 5) step();
    chk(!tx_en, "R5", "enable while tx busy", tx_en, 0);
    tx_idle = 1'b1; step();
    chk(tx_en, "R5", "enable one edge after quiet", tx_en, 1);
    drop_exact("R7");

    rx_active = 1'b1; sig_ok = 1'b1;
    repeat (Q + WMAX + 5) step();
    chk(!tx_en, "R5", "enable while rx active", tx_en, 0);
    rx_active = 1'b0; step();
    chk(tx_en, "R5", "enable one edge after rx idle", tx_en, 1);
    drop_exact("R7");

    // R6: abort during the wait
    sig_ok = 1'b1;
    repeat (Q + 3) step();
    sig_ok = 1'b0; step();
    chk(!tx_en, "R6", "enable after wait abort", tx_en, 0);
    measure_rise("R6");
    drop_exact("R7");

    // R6: abort during the quiet hold
    tx_idle = 1'b0; sig_ok = 1'b1;
    repeat (Q + WMAX + 3) step();
    sig_ok = 1'b0; step();
    tx_idle = 1'b1;
    chk(!tx_en, "R6", "enable after hold abort", tx_en, 0);
    measure_rise("R6");
    drop_exact("R7");

    // R4: random short runs followed by a sustained run
    for (int it = 0; it < 8; it++) begin
      int hi, lo;
      bad = 0;
      for (int k = 0; k < 3; k++) begin
        hi = $urandom_range(Q - 1, 1);
        lo = $urandom_range(3, 1);
        sig_ok = 1'b1; repeat (hi) begin step(); if (tx_en) bad++; end
        sig_ok = 1'b0; repeat (lo) begin step(); if (tx_en) bad++; end
      end
      chk(bad == 0, "R3", "enables during short runs", bad, 0);
      measure_rise("R4");
      drop_exact("R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule